// File: doc/BRIEF.md
# Debug Cycle Counter with Breakpoint

This block is a 16-bit general-purpose counter inside an on-chip debug unit. A debug controller supplies a level that is high while the core is halted. The counter reacts to the edges of that level. While the core is halted, a host-side port can load the counter and read it. Transfer logic can also step it down, one byte at a time, with a strobe. While the core runs, the counter does one of four things, chosen by a mode code: it holds its value, it measures elapsed clock cycles, it counts down to a break request, or it raises a break request when its value equals the program counter.

The mode code is captured only while the core is halted. Changing it while the core runs has no effect. Transfer commands reuse the same register, so a breakpoint value has to be the last thing written before the core is released. A break request is a one-cycle pulse. Each release of the core allows at most one pulse.

Top module: `dbg_cycle_counter`

## Requirements
- R1: A synchronous active-high reset clears the counter to 0x0000, clears the break output to 0 and sets the mode to hold (00).
- R2: In cycle mode (code 01), the first clock edge with `debug_i` low after an edge with it high loads the counter with 0x0000.
- R3: In cycle mode, each later edge with `debug_i` low adds one. Edges with `debug_i` high keep the value.
- R4: In cycle mode, the counter stops at 0xFFFF and holds there without wrapping.
- R5: In countdown mode (code 10), each running edge takes one off the counter, down to 0x0000 and no lower. The break pulse appears on the edge where the counter becomes 0x0000, or on the first running edge if it is already 0x0000.
- R6: In PC-match mode (code 11), an edge with `debug_i` low while `cnt_o` equals `pc_i` produces the break pulse. The counter keeps its value.
- R7: `brk_o` is high for one cycle at most. It stays low on any edge where `debug_i` is high. After one pulse, no further pulse comes until `debug_i` has gone high and then low again.
- R8: `wr_en_i` loads `wr_data_i` on the next edge. This takes priority over counting and over the byte strobe. The value is always visible on `cnt_o`.
- R9: With `debug_i` high, `byte_dec_i` takes one off the counter per edge. At 0x0000 the counter holds.
- R10: The mode is taken from `mode_i` only on edges with `debug_i` high. In hold mode (00), the counter keeps its value while the core runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| debug_i | input | 1 | High while the core is halted in debug mode |
| mode_i | input | 2 | Behaviour code: 00 hold, 01 cycle, 10 countdown, 11 PC match |
| wr_en_i | input | 1 | Load strobe for the counter |
| wr_data_i | input | 16 | Value to load |
| byte_dec_i | input | 1 | Byte-transfer decrement strobe |
| pc_i | input | 16 | Current program counter of the core |
| cnt_o | output | 16 | Present counter value |
| brk_o | output | 1 | One-cycle break request |

## Verification
The cycle count is run over a short window and then over a run longer than 65,536 cycles. The short window shows that the value clears on release and then increments. The long run shows that it saturates rather than wraps. The countdown is started once from 5 and once from 0. This separates firing on the transition to zero from firing on an already-zero value, and shows that no second pulse follows. The PC-match check holds the program counter off the stored value and then on it, first while the core is halted and then while it runs. It then halts and releases the core again, which shows that matches are suppressed while halted and that a fresh release re-arms the break. Writes that collide with the byte strobe, byte strobes at zero, and mode changes made while the core runs show how the different updates take priority over one another.

// File: rtl/dbg_cnt_pkg.sv
package dbg_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'b00,
    MODE_CYCLE   = 2'b01,
    MODE_DOWN    = 2'b10,
    MODE_PCMATCH = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/dbg_cnt_ctrl.sv
module dbg_cnt_ctrl
  import dbg_cnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      debug_i,
  input  logic [1:0] mode_i,
  output cnt_mode_e mode_o,
  output logic      run_o,
  output logic      exit_o
);
  cnt_mode_e mode_q;
  logic      dbg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_HOLD;
      dbg_q  <= 1'b0;
    end else begin
      dbg_q <= debug_i;
      if (debug_i) mode_q <= cnt_mode_e'(mode_i);
    end
  end

  assign mode_o = mode_q;
  assign run_o  = !debug_i;
  assign exit_o = dbg_q && !debug_i;

  // R10: the mode is frozen while the core runs
  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !debug_i |=> $stable(mode_q));
endmodule

// File: rtl/dbg_cnt_core.sv
module dbg_cnt_core
  import dbg_cnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             exit_i,
  input  cnt_mode_e        mode_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             byte_dec_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en_i) begin
      cnt_d = wr_data_i;
    end else if (!run_i) begin
      if (byte_dec_i && cnt_q != ZERO) cnt_d = cnt_q - ONE;
    end else begin
      case (mode_i)
        MODE_CYCLE: begin
          if (exit_i)           cnt_d = ZERO;
          else if (cnt_q != TOP) cnt_d = cnt_q + ONE;
        end
        MODE_DOWN: begin
          if (cnt_q != ZERO) cnt_d = cnt_q - ONE;
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_write_load_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> cnt_q == $past(wr_data_i));
  assert_clear_on_exit_R2: assert property (@(posedge clk) disable iff (rst)
    (exit_i && mode_i == MODE_CYCLE && !wr_en_i) |=> cnt_q == ZERO);
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (run_i && !exit_i && mode_i == MODE_CYCLE && !wr_en_i && cnt_q == TOP)
    |=> cnt_q == TOP);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_i && byte_dec_i && !wr_en_i && cnt_q == ZERO) |=> cnt_q == ZERO);
  assert_down_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (run_i && mode_i == MODE_DOWN && !wr_en_i && cnt_q == ZERO) |=> cnt_q == ZERO);
endmodule

// File: rtl/dbg_cnt_brk.sv
module dbg_cnt_brk
  import dbg_cnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             exit_i,
  input  cnt_mode_e        mode_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] pc_i,
  output logic             brk_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic armed_q, armed_now, hit, fire, brk_q;

  assign armed_now = armed_q || exit_i;
  assign hit = (mode_i == MODE_DOWN    && cnt_i <= ONE) ||
               (mode_i == MODE_PCMATCH && cnt_i == pc_i);
  assign fire = run_i && armed_now && !wr_en_i && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      brk_q   <= fire;
      armed_q <= run_i && armed_now && !fire;
    end
  end

  assign brk_o = brk_q;

  assert_brk_single_R7: assert property (@(posedge clk) disable iff (rst)
    brk_q |=> !brk_q);
  assert_brk_quiet_halted_R7: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !brk_q);
  assert_pc_match_R6: assert property (@(posedge clk) disable iff (rst)
    (exit_i && mode_i == MODE_PCMATCH && !wr_en_i && cnt_i == pc_i) |=> brk_q);
endmodule

// File: rtl/dbg_cycle_counter.sv
module dbg_cycle_counter
  import dbg_cnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             debug_i,
  input  logic [1:0]       mode_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             byte_dec_i,
  input  logic [WIDTH-1:0] pc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             brk_o
);
  cnt_mode_e        mode;
  logic             run, exit_edge;
  logic [WIDTH-1:0] cnt;

  dbg_cnt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .debug_i(debug_i), .mode_i(mode_i),
    .mode_o(mode), .run_o(run), .exit_o(exit_edge)
  );

  dbg_cnt_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .run_i(run), .exit_i(exit_edge), .mode_i(mode),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .byte_dec_i(byte_dec_i),
    .cnt_o(cnt)
  );

  dbg_cnt_brk #(.WIDTH(WIDTH)) u_brk (
    .clk(clk), .rst(rst), .run_i(run), .exit_i(exit_edge), .mode_i(mode),
    .wr_en_i(wr_en_i), .cnt_i(cnt), .pc_i(pc_i), .brk_o(brk_o)
  );

  assign cnt_o = cnt;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cnt_o == '0 && !brk_o));
endmodule

// File: tb/sim_dbg_cycle_counter.sv
`timescale 1ns/1ps
module sim_dbg_cycle_counter;
  typedef struct {
    logic [15:0] cnt;
    logic        brk;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        debug_i = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        byte_dec_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [15:0] cnt_o;
  logic        brk_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dbg_cycle_counter u0 (
    .clk(clk), .rst(rst), .debug_i(debug_i), .mode_i(mode_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .byte_dec_i(byte_dec_i),
    .pc_i(pc_i), .cnt_o(cnt_o), .brk_o(brk_o)
  );

  // driver: one clock edge, then queue what the outputs must show after it
  task automatic step(input bit chk, input logic [15:0] ec, input logic eb,
                      input string tag);
    exp_t e;
    @(posedge clk);
    if (chk) begin
      e.cnt = ec; e.brk = eb; e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (cnt_o !== e.cnt || brk_o !== e.brk) begin
        n_fail++;
        $display("FAIL %s: cnt=%h brk=%b expected cnt=%h brk=%b",
                 e.tag, cnt_o, brk_o, e.cnt, e.brk);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, ""); step(0, 0, 0, "");
    rst = 1'b0;
    step(1, 16'h0000, 0, "R1 reset state");

    // loads and byte strobe while halted
    wr_en_i = 1; wr_data_i = 16'h0002;
    step(1, 16'h0002, 0, "R8 load");
    wr_en_i = 0; byte_dec_i = 1;
    step(1, 16'h0001, 0, "R9 byte dec");
    step(1, 16'h0000, 0, "R9 byte dec to zero");
    step(1, 16'h0000, 0, "R9 no underflow");
    wr_en_i = 1; wr_data_i = 16'h0007;
    step(1, 16'h0007, 0, "R8 load beats byte strobe");
    wr_en_i = 0; byte_dec_i = 0;

    // cycle counting
    mode_i = 2'b01; wr_en_i = 1; wr_data_i = 16'h1234;
    step(1, 16'h1234, 0, "R8 load before release");
    wr_en_i = 0; debug_i = 0;
    step(1, 16'h0000, 0, "R2 clear on release");
    step(1, 16'h0001, 0, "R3 count");
    step(1, 16'h0002, 0, "R3 count");
    mode_i = 2'b10;
    step(1, 16'h0003, 0, "R10 mode change ignored while running");
    step(1, 16'h0004, 0, "R10 mode change ignored while running");
    debug_i = 1;
    step(1, 16'h0004, 0, "R3 hold on halt");
    step(1, 16'h0004, 0, "R3 hold on halt");

    // saturation
    mode_i = 2'b01;
    step(1, 16'h0004, 0, "R3 hold while halted");
    debug_i = 0;
    for (int i = 0; i < 65538; i++) step(0, 0, 0, "");
    step(1, 16'hFFFF, 0, "R4 saturate");
    step(1, 16'hFFFF, 0, "R4 no wrap");
    debug_i = 1;
    step(1, 16'hFFFF, 0, "R3 hold on halt");
    debug_i = 0;
    step(1, 16'h0000, 0, "R2 clear on second release");
    debug_i = 1;
    step(1, 16'h0000, 0, "R3 hold on halt");

    // countdown from 5
    mode_i = 2'b10; wr_en_i = 1; wr_data_i = 16'h0005;
    step(1, 16'h0005, 0, "R8 load countdown");
    wr_en_i = 0; debug_i = 0;
    step(1, 16'h0004, 0, "R5 down");
    step(1, 16'h0003, 0, "R5 down");
    step(1, 16'h0002, 0, "R5 down");
    step(1, 16'h0001, 0, "R5 down");
    step(1, 16'h0000, 1, "R5 break at zero");
    step(1, 16'h0000, 0, "R7 single pulse");
    step(1, 16'h0000, 0, "R7 no repeat");
    debug_i = 1;
    step(1, 16'h0000, 0, "R7 quiet halted");
    // countdown already at zero
    debug_i = 0;
    step(1, 16'h0000, 1, "R5 break when already zero");
    step(1, 16'h0000, 0, "R7 single pulse");
    debug_i = 1;
    step(1, 16'h0000, 0, "R7 quiet halted");

    // PC match
    mode_i = 2'b11; pc_i = 16'h0040; wr_en_i = 1; wr_data_i = 16'h0080;
    step(1, 16'h0080, 0, "R8 load match value");
    wr_en_i = 0; pc_i = 16'h0080;
    step(1, 16'h0080, 0, "R7 match suppressed while halted");
    pc_i = 16'h0040; debug_i = 0;
    step(1, 16'h0080, 0, "R6 no match");
    step(1, 16'h0080, 0, "R6 no match");
    pc_i = 16'h0080;
    step(1, 16'h0080, 1, "R6 match break");
    step(1, 16'h0080, 0, "R7 once per release");
    step(1, 16'h0080, 0, "R7 once per release");
    debug_i = 1;
    step(1, 16'h0080, 0, "R7 quiet halted");
    debug_i = 0;
    step(1, 16'h0080, 1, "R7 rearmed by new release");
    step(1, 16'h0080, 0, "R7 single pulse");

    // hold mode
    debug_i = 1; mode_i = 2'b00;
    step(1, 16'h0080, 0, "R10 hold select");
    debug_i = 0;
    step(1, 16'h0080, 0, "R10 hold while running");
    step(1, 16'h0080, 0, "R10 hold while running");
    wr_en_i = 1; wr_data_i = 16'h0055;
    step(1, 16'h0055, 0, "R8 load while running");
    wr_en_i = 0;
    step(1, 16'h0055, 0, "R10 hold after load");

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule